// File: doc/BRIEF.md
# Receive Elasticity Buffer with Threshold Start

This block sits between the bit recovery stage of a serial receiver and the local receive logic. The recovered bit stream arrives on a write strobe, and the local side pulls bits out on its own read strobe. Both run from the one local clock. When the two bit rates differ slightly, the occupancy of the buffer drifts up or down over a packet, and the block absorbs that drift without losing bits.

Readout is held back at the start of a packet until enough bits have built up to cover the worst-case drift in either direction. Only then does the start output rise to enable the downstream receiver. If the drift still exceeds the margin, an overflow or an underflow results, and the block flags it on a sticky error output. A packet-end clear returns the block to empty for the next packet.

The default sizing assumes up to ±500 ppm of clock mismatch. Over a maximum-length packet this gives about ±12 bits of drift, so the defaults are a 32-bit store and a start threshold of 16.

Top module: `rx_elastic_buf`

## Requirements
- R1: After reset, `rd_valid`, `started` and `rx_err` are all 0 and the buffer is empty.
- R2: Bits accepted on `wr_en` come out in the order they were written. For each accepted read strobe, `rd_valid` is 1 and `rd_bit` carries the bit during the cycle after the strobe, and `rd_valid` is 0 in every other cycle.
- R3: A read strobe given before `started` is 1 is ignored: it outputs nothing, removes no bit and raises no error.
- R4: `started` rises at the same clock edge that stores the THRESH-th bit (16 by default). It then stays 1 until a clear.
- R5: A write strobe that finds the buffer holding DEPTH bits (32 by default) drops its bit and sets `rx_err`. This also applies when a read strobe is given in the same cycle.
- R6: A read strobe after start that finds the buffer empty sets `rx_err`, and `rd_valid` stays 0 in the following cycle.
- R7: Once set, `rx_err` stays 1 until a clear.
- R8: When `clr` is 1, the buffer is emptied at that edge and `started`, `rx_err` and `rd_valid` return to 0. Any write or read strobe in the same cycle is ignored.
- R9: A write and a read strobe in the same cycle on a non-empty buffer both take effect, and the occupancy is unchanged.
- R10: The defaults leave room for 12 bits of drift on each side of the threshold. Filling to threshold plus 12 bits raises no error, and after start, draining all 16 threshold bits raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Packet-end clear: empty buffer, drop flags |
| wr_en | input | 1 | Write strobe from the recovered-clock side |
| wr_bit | input | 1 | Received bit to store |
| rd_en | input | 1 | Local read strobe |
| rd_bit | output | 1 | Bit read out, meaningful while rd_valid is 1 |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| started | output | 1 | Threshold reached; downstream receive enable |
| rx_err | output | 1 | Sticky overflow/underflow error |

## Verification
The bench checks the exact edge where `started` rises: a design that compares the old occupancy instead of the new one rises a cycle late. It also checks that a read before start neither pops a bit nor raises an error, which a design that does either would betray by returning a shifted stream.

For overflow, the bench writes to a full buffer while reading in the same cycle and then drains it. A design that lets the read make room would deliver one bit too many. Concurrent write and read on a loaded buffer are followed by a full drain and one extra read, which exposes any occupancy miscount. A clear that coincides with a write would leave a stale bit and make `started` rise one write early.

// File: rtl/erb_pkg.sv
// Shared types for the receive elasticity buffer.
// Assumes: single clock; one event record per cycle from controller to store.
package erb_pkg;

    // Per-cycle decision taken by the controller
    typedef struct packed {
        logic push;   // store the incoming bit
        logic pop;    // read out the oldest bit
        logic ovf;    // write dropped on a full buffer
        logic unf;    // read on an empty buffer after start
    } erb_evt_t;

endpackage

// File: rtl/erb_ctrl.sv
// Occupancy, start and error control for the elasticity buffer.
// Decides each cycle whether a write is stored or dropped and whether a read
// pops or underflows. Reads are ignored until the start threshold is met.
// Assumes: clr has priority over both strobes; reset is synchronous.
module erb_ctrl
    import erb_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int THRESH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          rd_en,
    output erb_evt_t      evt,
    output logic [CW-1:0] fill,
    output logic          started,
    output logic          rx_err
);

    logic [CW-1:0] fill_q, fill_d;
    logic          started_q, err_q;
    logic          full, empty;

    // Classify this cycle's strobes against the current occupancy
    always_comb begin
        full      = (fill_q == CW'(DEPTH));
        empty     = (fill_q == '0);
        evt.push  = !clr && wr_en && !full;
        evt.ovf   = !clr && wr_en && full;
        evt.pop   = !clr && rd_en && started_q && !empty;
        evt.unf   = !clr && rd_en && started_q && empty;
        fill_d    = fill_q + CW'(evt.push) - CW'(evt.pop);
    end

    // Occupancy, sticky start and sticky error registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fill_q    <= '0;
            started_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            fill_q    <= fill_d;
            started_q <= started_q || (fill_d >= CW'(THRESH));
            err_q     <= err_q || evt.ovf || evt.unf;
        end
    end

    assign fill    = fill_q;
    assign started = started_q;
    assign rx_err  = err_q;

    // R5
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && fill == CW'(DEPTH)) |=> rx_err);
    // R6
    unf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !clr && started && fill == '0) |=> rx_err);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && !clr) |=> rx_err);
    // R4
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !clr) |=> started);
    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill == '0 && !started && !rx_err));
    // R5
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

endmodule

// File: rtl/erb_store.sv
// Bit storage ring with registered read port.
// Writes the incoming bit on push and registers the oldest bit on pop; the
// output is valid for exactly the cycle after a pop.
// Assumes: the controller never pushes when full nor pops when empty.
module erb_store
    import erb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  erb_evt_t evt,
    input  logic     wr_bit,
    output logic     rd_bit,
    output logic     rd_valid
);

    logic [DEPTH-1:0] mem;
    logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;

    // Pointer advance: natural wrap for power-of-two depth, compare otherwise
    generate
        if (DEPTH == (1 << AW)) begin : g_pow2
            assign wptr_nx = wptr + 1'b1;
            assign rptr_nx = rptr + 1'b1;
        end else begin : g_mod
            assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        end
    endgenerate

    // Storage write; contents need no reset since pointers guard them
    always_ff @(posedge clk) begin
        if (evt.push) mem[wptr] <= wr_bit;
    end

    // Write and read pointers
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (evt.push) wptr <= wptr_nx;
            if (evt.pop)  rptr <= rptr_nx;
        end
    end

    // Registered read output and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_bit   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= evt.pop;
            if (evt.pop) rd_bit <= mem[rptr];
        end
    end

endmodule

// File: rtl/rx_elastic_buf.sv
// Receive elasticity buffer: bit FIFO that holds readout until the fill
// reaches THRESH, then raises started and serves one bit per read strobe.
// Overflow and underflow set a sticky error cleared only by clr.
// Assumes: wr_en and rd_en are single-cycle strobes on the local clock.
module rx_elastic_buf
    import erb_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int THRESH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic rd_en,
    output logic rd_bit,
    output logic rd_valid,
    output logic started,
    output logic rx_err
);

    localparam int CW = $clog2(DEPTH + 1);

    erb_evt_t      evt;
    logic [CW-1:0] fill;

    erb_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .evt     (evt),
        .fill    (fill),
        .started (started),
        .rx_err  (rx_err)
    );

    erb_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .evt      (evt),
        .wr_bit   (wr_bit),
        .rd_bit   (rd_bit),
        .rd_valid (rd_valid)
    );

    // R3
    no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !started |=> !rd_valid);
    // R6
    unf_noval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && started && fill == '0) |=> !rd_valid);
    // R2
    idle_noval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

// File: tb/rx_elastic_buf_test.sv
// Directed bench for rx_elastic_buf: one task per scenario.
module rx_elastic_buf_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0;
    logic rd_bit, rd_valid, started, rx_err;
    int   n_chk = 0, n_bad = 0;

    rx_elastic_buf #(.DEPTH(32), .THRESH(16)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_bit(wr_bit),
        .rd_en(rd_en), .rd_bit(rd_bit), .rd_valid(rd_valid),
        .started(started), .rx_err(rx_err)
    );

    always #5 clk = ~clk;

    function automatic logic pat(input int i);
        logic [31:0] h;
        h = i * 37 + 5;
        return ^(h ^ (h >> 3));
    endfunction

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge; outputs are sampled at the next one
    task automatic cyc(input logic w, input logic wb, input logic r, input logic c);
        wr_en = w; wr_bit = wb; rd_en = r; clr = c;
        @(negedge clk);
        wr_en = 1'b0; wr_bit = 1'b0; rd_en = 1'b0; clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rd_valid", rd_valid, 1'b0);
        chk("R1", "started", started, 1'b0);
        chk("R1", "rx_err", rx_err, 1'b0);
    endtask

    task automatic t_fill_drain();
        cyc(0, 0, 0, 1);
        for (int i = 0; i < 5; i++) cyc(1, pat(i), 0, 0);
        cyc(0, 0, 1, 0);
        chk("R3", "early read valid", rd_valid, 1'b0);
        chk("R3", "early read err", rx_err, 1'b0);
        for (int i = 5; i < 15; i++) cyc(1, pat(i), 0, 0);
        chk("R4", "started at 15", started, 1'b0);
        cyc(1, pat(15), 0, 0);
        chk("R4", "started at 16", started, 1'b1);
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 1, 0);
            chk("R2", "valid", rd_valid, 1'b1);
            chk("R2", "order", rd_bit, pat(i));
        end
        cyc(0, 0, 0, 0);
        chk("R2", "valid drops", rd_valid, 1'b0);
        chk("R10", "drain no err", rx_err, 1'b0);
        cyc(0, 0, 1, 0);
        chk("R6", "underflow valid", rd_valid, 1'b0);
        chk("R6", "underflow err", rx_err, 1'b1);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
        cyc(1, 1, 0, 0);
        chk("R7", "err sticky", rx_err, 1'b1);
        chk("R4", "started held", started, 1'b1);
        cyc(0, 0, 0, 1);
        chk("R8", "started cleared", started, 1'b0);
        chk("R8", "err cleared", rx_err, 1'b0);
    endtask

    task automatic t_overflow();
        cyc(0, 0, 0, 1);
        for (int i = 0; i < 28; i++) cyc(1, pat(i), 0, 0);
        chk("R10", "threshold+12 no err", rx_err, 1'b0);
        for (int i = 28; i < 32; i++) cyc(1, pat(i), 0, 0);
        chk("R5", "full no err yet", rx_err, 1'b0);
        cyc(1, pat(32), 1, 0);
        chk("R5", "overflow err", rx_err, 1'b1);
        chk("R5", "concurrent read valid", rd_valid, 1'b1);
        chk("R5", "concurrent read bit", rd_bit, pat(0));
        for (int i = 1; i < 32; i++) begin
            cyc(0, 0, 1, 0);
            chk("R5", "kept bit", rd_bit, pat(i));
        end
        cyc(0, 0, 1, 0);
        chk("R5", "dropped bit absent", rd_valid, 1'b0);
    endtask

    task automatic t_simul();
        cyc(0, 0, 0, 1);
        for (int i = 0; i < 16; i++) cyc(1, pat(i), 0, 0);
        for (int k = 0; k < 20; k++) begin
            cyc(1, pat(16 + k), 1, 0);
            chk("R9", "stream valid", rd_valid, 1'b1);
            chk("R9", "stream bit", rd_bit, pat(k));
        end
        chk("R9", "no err", rx_err, 1'b0);
        for (int i = 20; i < 36; i++) begin
            cyc(0, 0, 1, 0);
            chk("R9", "drain bit", rd_bit, pat(i));
        end
        cyc(0, 0, 1, 0);
        chk("R9", "exact occupancy", rd_valid, 1'b0);
        chk("R6", "underflow after drain", rx_err, 1'b1);
    endtask

    task automatic t_clear_ignores();
        cyc(0, 0, 0, 1);
        for (int i = 0; i < 10; i++) cyc(1, pat(50 + i), 0, 0);
        cyc(1, 1, 1, 1);
        chk("R8", "clear valid", rd_valid, 1'b0);
        for (int i = 0; i < 15; i++) cyc(1, pat(100 + i), 0, 0);
        chk("R8", "clear-cycle write ignored", started, 1'b0);
        cyc(1, pat(115), 0, 0);
        chk("R4", "start after clear", started, 1'b1);
        for (int i = 0; i < 16; i++) begin
            cyc(0, 0, 1, 0);
            chk("R8", "fresh content", rd_bit, pat(100 + i));
        end
        chk("R8", "no err", rx_err, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_drain();
        t_overflow();
        t_simul();
        t_clear_ignores();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule